// File: doc/BRIEF.md
# Receive Character Queue with Interrupt Flags

This block sits between a serial deserializer and a register bus in a UART. Each character the deserializer delivers comes with three error tags (break, framing, parity). The block keeps the character and its tags in a 32-entry first-in first-out store. Software reads the characters back through a small register window.

Three interrupt sources combine into one request line: data-available, idle timeout and buffer error. Data-available fires when the fill reaches a coded threshold. Idle timeout fires when characters have waited too long without any traffic. Buffer error fires on overflow. Each source has its own enable. The idle timer is counted in bit times, taken from a one-per-bit tick that the baud generator supplies. Software can empty the store with a write-only flush bit. Overflow and the three error tags are reported as sticky flags, and writing one to a flag clears it.

Register window (`reg_addr`): 0 = data, 1 = control, 2 = status, 3 = timeout limit, 4 = interrupt flags. Reads return their value in the same cycle. A data read removes a character at the clock edge on which `reg_rd` is high.

Top module: `rx_char_queue`

## Requirements
- R1: Characters leave in arrival order, up to 32 held. Status bit 4 is empty, bit 5 is full and bits [13:8] hold the occupancy. After reset the store is empty, the interrupt flags read 0 and `irq` is low.
- R2: Control bits [3:0] hold the trigger code: 0 means 1 byte, 1 means 4, 2 means 8, 3 means 14, and 4 or above means 30. Interrupt-flag bit 0 is high while the occupancy is at or above that threshold.
- R3: `irq` is high exactly when some flag is set whose enable is set. Control bit 4 enables data-available, bit 5 enables timeout and bit 7 enables buffer error.
- R4: Control bit 6 runs the idle counter. With it set and the store non-empty, interrupt-flag bit 1 rises after exactly `limit` ticks of `bit_tick` with no character arriving and no data read. The limit is in register 3 and is 0x40 after reset. With bit 6 clear the flag stays low.
- R5: Every accepted character and every data read restarts the idle count. Emptying the store drops the timeout flag.
- R6: A character that arrives while the store is full and no read happens that cycle is discarded. It sets sticky status bit 0 and interrupt-flag bit 2.
- R7: Status bits 1, 2 and 3 (parity, framing, break) show the tags of the character at the head. Once a tagged character has been read out, its flag stays set.
- R8: Writing 1 to status bits [3:0] clears the matching sticky flags. Writing 0 leaves them unchanged.
- R9: Writing control with bit 8 set empties the store in one cycle. Bit 8 itself is not stored.
- R10: A data read with the store empty returns the last character read and leaves the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Deserializer delivers a character this cycle |
| in_data | input | 8 | Received character |
| in_brk | input | 1 | Break tag for the character |
| in_frm | input | 1 | Framing-error tag |
| in_par | input | 1 | Parity-error tag |
| bit_tick | input | 1 | One pulse per bit time |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data reads) |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 16 | Read data, valid in the same cycle |
| irq | output | 1 | Combined interrupt request |

## Verification
Occupancy, status, flags and `irq` all change in the first sampling window after the clock edge that takes a push, pop, flush or write. The bench therefore drives on the falling edge and samples on the next falling edge. Read data is combinational, so the scoreboard monitor compares it at the rising edge that performs the pop. The idle timeout is checked at two points a single edge apart: one cycle before the limit is reached, when the flag must still be low, and exactly at the limit, counting the edge that restarted the count as edge zero.

// File: rtl/rxq_pkg.sv
// Shared types and constants for the receive character queue.
// Assumes an 8-bit character and a 16-bit read window.
package rxq_pkg;
    localparam int CHAR_W = 8;
    localparam int RD_W   = 16;
    localparam int WR_W   = 9;

    localparam logic [2:0] A_DATA  = 3'd0;
    localparam logic [2:0] A_CTRL  = 3'd1;
    localparam logic [2:0] A_STAT  = 3'd2;
    localparam logic [2:0] A_LIMIT = 3'd3;
    localparam logic [2:0] A_FLAGS = 3'd4;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rx_entry_t;

    // Map the coded trigger field to a byte threshold.
    function automatic logic [7:0] trig_bytes(input logic [3:0] code);
        case (code)
            4'd0:    trig_bytes = 8'd1;
            4'd1:    trig_bytes = 8'd4;
            4'd2:    trig_bytes = 8'd8;
            4'd3:    trig_bytes = 8'd14;
            default: trig_bytes = 8'd30;
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Tagged first-in first-out store. The head is read combinationally.
// Assumes DEPTH is a power of two. A flush overrides push and pop.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  rx_entry_t     wr_entry,
    input  logic          pop,
    input  logic          flush,
    output rx_entry_t     head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          drop
);
    rx_entry_t     mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign drop    = push && full && !do_pop && !flush;
    assign head    = mem[rp_q];
    assign count   = cnt_q;

    // Write the arriving character into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp_q] <= wr_entry;
    end

    // Move the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (cnt_q == $past(cnt_q)));
    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (cnt_q == '0));
endmodule

// File: rtl/rxq_idle_timer.sv
// Idle counter in bit times. It restarts on traffic and resets when disabled or empty.
// Assumes bit_tick is a single-cycle pulse. The count saturates at the limit.
module rxq_idle_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          nonempty,
    input  logic          restart,
    input  logic          bit_tick,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt_q;

    // Count ticks while enabled and holding data, restarting on traffic.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !enable || !nonempty)
            cnt_q <= '0;
        else if (bit_tick && cnt_q < limit)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = enable && nonempty && (cnt_q >= limit);

    assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));
endmodule

// File: rtl/rxq_trigger.sv
// Compare the occupancy against the decoded trigger threshold.
// Assumes the occupancy fits in eight bits.
module rxq_trigger
    import rxq_pkg::*;
#(
    parameter int CW = 6
) (
    input  logic [3:0]    code,
    input  logic [CW-1:0] count,
    output logic          avail
);
    assign avail = (8'(count) >= trig_bytes(code));
endmodule

// File: rtl/rx_char_queue.sv
// Receive character queue with a register window and interrupt flags.
// Assumes one character per cycle at most and a synchronous register bus.
module rx_char_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int TW        = 8,
    parameter int LIMIT_RST = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              in_brk,
    input  logic              in_frm,
    input  logic              in_par,
    input  logic              bit_tick,
    input  logic [2:0]        reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [WR_W-1:0]   reg_wdata,
    output logic [RD_W-1:0]   reg_rdata,
    output logic              irq
);
    rx_entry_t         head, wr_entry;
    logic [CW-1:0]     count;
    logic              empty, full, drop, pop, flush, avail, expired;
    logic [7:0]        ctrl_q;
    logic [TW-1:0]     limit_q;
    logic [CHAR_W-1:0] last_q;
    logic              ovf_q, par_q, frm_q, brk_q;
    logic [3:0]        w1c;
    logic [2:0]        flags;

    assign wr_entry = '{brk: in_brk, frm: in_frm, par: in_par, data: in_data};
    assign pop      = reg_rd && (reg_addr == A_DATA) && !empty;
    assign flush    = reg_wr && (reg_addr == A_CTRL) && reg_wdata[8];
    assign w1c      = (reg_wr && reg_addr == A_STAT) ? reg_wdata[3:0] : 4'b0;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(in_valid), .wr_entry(wr_entry),
        .pop(pop), .flush(flush), .head(head), .count(count),
        .empty(empty), .full(full), .drop(drop)
    );

    rxq_idle_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .enable(ctrl_q[6]), .nonempty(!empty),
        .restart(in_valid || pop), .bit_tick(bit_tick), .limit(limit_q),
        .expired(expired)
    );

    rxq_trigger #(.CW(CW)) u_trig (
        .code(ctrl_q[3:0]), .count(count), .avail(avail)
    );

    // Hold the control fields and the timeout limit written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            limit_q <= TW'(LIMIT_RST);
        end else if (reg_wr) begin
            if (reg_addr == A_CTRL)  ctrl_q  <= reg_wdata[7:0];
            if (reg_addr == A_LIMIT) limit_q <= reg_wdata[TW-1:0];
        end
    end

    // Remember the most recently read character for reads of an empty store.
    always_ff @(posedge clk) begin
        if (!rst_n)   last_q <= '0;
        else if (pop) last_q <= head.data;
    end

    // Sticky flags: set by overflow or by reading a tagged character, cleared by writing 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {brk_q, frm_q, par_q, ovf_q} <= '0;
        end else begin
            ovf_q <= (ovf_q & ~w1c[0]) | drop;
            par_q <= (par_q & ~w1c[1]) | (pop & head.par);
            frm_q <= (frm_q & ~w1c[2]) | (pop & head.frm);
            brk_q <= (brk_q & ~w1c[3]) | (pop & head.brk);
        end
    end

    assign flags = {ovf_q, expired, avail};
    assign irq   = (flags[0] & ctrl_q[4]) | (flags[1] & ctrl_q[5]) | (flags[2] & ctrl_q[7]);

    // Select the register returned on the read window.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DATA:  reg_rdata[CHAR_W-1:0] = empty ? last_q : head.data;
            A_CTRL:  reg_rdata[7:0] = ctrl_q;
            A_STAT: begin
                reg_rdata[0]       = ovf_q;
                reg_rdata[1]       = par_q | (!empty & head.par);
                reg_rdata[2]       = frm_q | (!empty & head.frm);
                reg_rdata[3]       = brk_q | (!empty & head.brk);
                reg_rdata[4]       = empty;
                reg_rdata[5]       = full;
                reg_rdata[8 +: CW] = count;
            end
            A_LIMIT: reg_rdata[TW-1:0] = limit_q;
            A_FLAGS: reg_rdata[2:0] = flags;
            default: reg_rdata = '0;
        endcase
    end

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> ovf_q);
    assert_ovf_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !w1c[0]) |=> ovf_q);
    assert_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_DATA && empty && !in_valid) |=> (count == '0));
endmodule

// File: tb/test_rx_char_queue.sv
module test_rx_char_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 0, in_brk = 0, in_frm = 0, in_par = 0, bit_tick = 0;
    logic [7:0]  in_data = 0;
    logic [2:0]  reg_addr = 0;
    logic        reg_wr = 0, reg_rd = 0;
    logic [8:0]  reg_wdata = 0;
    logic [15:0] reg_rdata;
    logic        irq;

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    logic [7:0] last_exp = 8'h00;

    always #2.5 clk = ~clk;

    rx_char_queue i_rx_char_queue (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_brk(in_brk), .in_frm(in_frm), .in_par(in_par), .bit_tick(bit_tick),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: deliver one character and record it in the scoreboard if it fits.
    task automatic push(input logic [7:0] d, input logic b, input logic f, input logic p);
        @(negedge clk);
        in_valid = 1; in_data = d; in_brk = b; in_frm = f; in_par = p;
        if (exp_q.size() < 32) exp_q.push_back(d);
        @(negedge clk);
        in_valid = 0; in_brk = 0; in_frm = 0; in_par = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [8:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1;
        if (a == 3'd1 && v[8]) exp_q.delete();
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic pop_one();
        @(negedge clk);
        reg_addr = 3'd0; reg_rd = 1;
        @(negedge clk);
        reg_rd = 0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    // Monitor: compare each popped character with the scoreboard head (R1, R10).
    always @(posedge clk) begin
        if (rst_n && reg_rd && reg_addr == 3'd0) begin
            if (exp_q.size() > 0) begin
                last_exp = exp_q.pop_front();
                check("R1 order", reg_rdata[7:0], last_exp);
            end else begin
                check("R10 empty read value", reg_rdata[7:0], last_exp);
            end
        end
    end

    initial begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        peek(3'd2, v); check("R1 reset status", v, 16'h0010);
        peek(3'd4, v); check("R1 reset flags", v, 0);
        check("R1 reset irq", irq, 0);
        peek(3'd3, v); check("R4 limit reset", v, 8'h40);

        // R1 ordering and count
        push(8'hA1, 0, 0, 0); push(8'hB2, 0, 0, 0); push(8'hC3, 0, 0, 0);
        peek(3'd2, v); check("R1 count 3", v[13:8], 3);
        repeat (3) pop_one();
        peek(3'd2, v); check("R1 empty again", v[4], 1);

        // R2/R3 trigger code 1 = 4 bytes, enabled
        wr(3'd1, 9'h011);
        for (int i = 0; i < 3; i++) push(8'(i), 0, 0, 0);
        check("R2 below 4 irq", irq, 0);
        push(8'h33, 0, 0, 0);
        check("R2 at 4 irq", irq, 1);
        peek(3'd4, v); check("R2 flag bit0", v[0], 1);
        // R3 disabled enable keeps irq low
        wr(3'd1, 9'h001);
        check("R3 disabled irq", irq, 0);
        // code 3 = 14
        wr(3'd1, 9'h013);
        for (int i = 0; i < 9; i++) push(8'(8'h40 + i), 0, 0, 0);
        check("R2 13 bytes code3", irq, 0);
        push(8'h4F, 0, 0, 0);
        check("R2 14 bytes code3", irq, 1);
        // code 4 = 30
        wr(3'd1, 9'h014);
        for (int i = 0; i < 15; i++) push(8'(8'h60 + i), 0, 0, 0);
        check("R2 29 bytes code4", irq, 0);
        push(8'h7F, 0, 0, 0);
        check("R2 30 bytes code4", irq, 1);

        // R6 fill and overflow with buffer-error enable only
        wr(3'd1, 9'h080);
        push(8'h80, 0, 0, 0); push(8'h81, 0, 0, 0);
        peek(3'd2, v); check("R1 full bit", v[5], 1);
        check("R6 no ovf yet", irq, 0);
        push(8'hEE, 0, 0, 0);
        peek(3'd2, v); check("R6 ovf sticky", v[0], 1);
        check("R6 count stays 32", v[13:8], 32);
        peek(3'd4, v); check("R6 buffer flag", v[2], 1);
        check("R6 irq", irq, 1);
        repeat (32) pop_one();
        peek(3'd2, v); check("R6 dropped char absent", v[4], 1);
        check("R6 ovf survives reads", v[0], 1);
        // R8 write 0 does nothing, write 1 clears
        wr(3'd2, 9'h000);
        peek(3'd2, v); check("R8 zero write", v[0], 1);
        wr(3'd2, 9'h001);
        peek(3'd2, v); check("R8 w1c ovf", v[0], 0);
        check("R8 irq drops", irq, 0);

        // R7 head tags and stickiness
        push(8'h11, 0, 0, 1); push(8'h22, 0, 1, 0); push(8'h33, 1, 0, 0);
        peek(3'd2, v); check("R7 head parity", v[3:1], 3'b001);
        pop_one();
        peek(3'd2, v); check("R7 parity sticky + head frame", v[3:1], 3'b011);
        wr(3'd2, 9'h002);
        peek(3'd2, v); check("R8 parity cleared", v[3:1], 3'b010);
        pop_one();
        peek(3'd2, v); check("R7 break at head", v[3:1], 3'b110);
        pop_one();
        wr(3'd2, 9'h00E);
        peek(3'd2, v); check("R8 all tags cleared", v[3:0], 0);

        // R4 timeout with limit 5, tick every cycle
        wr(3'd3, 9'd5);
        wr(3'd1, 9'h060);
        bit_tick = 1;
        push(8'h55, 0, 0, 0);
        repeat (4) @(negedge clk);
        check("R4 before limit", irq, 0);
        @(negedge clk);
        check("R4 at limit", irq, 1);
        // R5 read restarts and empties
        pop_one();
        peek(3'd4, v); check("R5 empty clears timeout", v[1], 0);
        // R5 restart on a new character
        push(8'h56, 0, 0, 0);
        repeat (2) @(negedge clk);
        push(8'h57, 0, 0, 0);
        repeat (4) @(negedge clk);
        check("R5 restarted not yet", irq, 0);
        @(negedge clk);
        check("R5 restarted at limit", irq, 1);
        // R4 counter enable off
        wr(3'd1, 9'h020);
        repeat (10) @(negedge clk);
        check("R4 counter disabled", irq, 0);
        bit_tick = 0;

        // R9 flush
        push(8'h99, 0, 0, 0);
        wr(3'd1, 9'h100);
        peek(3'd2, v); check("R9 flush count", v[13:8], 0);
        check("R9 flush empty", v[4], 1);
        peek(3'd1, v); check("R9 bit8 not stored", v, 0);

        // R10 empty read keeps last value and count
        push(8'hC7, 0, 0, 0);
        pop_one();
        pop_one();
        peek(3'd2, v); check("R10 count unchanged", v[13:8], 0);
        peek(3'd0, v); check("R10 data holds last", v[7:0], 8'hC7);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule